// File: doc/BRIEF.md
# Serial Flash Page-Erase Command Controller

This block is the device-side command logic of a small serial flash memory. A host drives chip select, serial clock and serial data in. The block decodes three commands: set write enable, read status, and page erase. It answers on the serial data out line. All serial pins are sampled by the system clock through two-stage synchronizers. This means the serial clock must run well below the system clock.

A page-erase command carries a 24-bit address. It runs only if three conditions hold:
- the write-enable latch was set by an earlier, separate frame;
- chip select rises in the serial-clock low phase straight after the 32nd bit;
- the addressed page is outside the region chosen by the two protection-level inputs.

The erase is self-timed. It writes 0xFF into each of the 256 bytes of the page, one byte per system clock. It holds the busy status bit for a parameterised number of clocks. It clears the write-enable latch when it starts. While busy, only the read-status command is honoured.

The internal byte array has a combinational read port. The data path that would use this port is not part of this block.

Top module: `flash_erase_ctl`

## Requirements
- R1: A frame begins when chip select falls. Serial input bits are captured on rising serial-clock edges while chip select is low, most significant bit first. The first eight bits form the opcode.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1). It does so only when chip select rises after exactly 8 bits. With any other bit count the latch is left as it was.
- R3: Opcode 0x05 returns the status byte {0000, PL1, PL0, WEL, BUSY}, most significant bit first. Each bit changes on a falling serial-clock edge. The byte repeats for as long as chip select stays low. Outside this command the serial output stays 0.
- R4: An accepted page erase (opcode 0xD8 plus 24 address bits) sets all 256 bytes of the page given by address bits [ARR_AW-1:8] to 0xFF. Address bits above that field and below bit 8 are ignored. Every other byte is unchanged.
- R5: A page erase sent while the write-enable latch is clear is dropped. No byte changes and the status stays as it was.
- R6: A page erase is accepted only when chip select rises with exactly 32 bits received and the serial clock low. With 31 bits, 33 bits, or chip select rising while the clock is high, the command is aborted. Nothing is erased and the write-enable latch is kept.
- R7: The protection level prot_lvl works as follows: 00 protects nothing, 01 protects the upper quarter of the pages, 10 the upper half, and 11 all pages. An erase aimed at a protected page does nothing and keeps the write-enable latch.
- R8: The busy bit (status bit 0) reads 1 from the start of an erase for ERASE_CYCLES system clocks. After that it reads 0.
- R9: The write-enable latch is cleared at the start of an erase and stays clear after the erase ends.
- R10: While busy, every opcode other than 0x05 is ignored for the rest of its frame. A write enable does not set the latch, and a page erase does not touch the array.
- R11: An unknown opcode makes the block ignore the rest of the frame, including bits that would form a valid command. Only a new falling edge of chip select starts a new frame.
- R12: After reset the status byte is 0 (when prot_lvl is 00), the serial output is 0, and every array byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| prot_lvl | input | 2 | Block-protection level |
| rd_addr | input | ARR_AW | Byte address of the array read port |
| rd_data | output | 8 | Byte read from the array, combinational |

## Verification
The assertions assume the following about the inputs:
- each serial-clock phase lasts several system clocks, so every synchronised edge is seen once;
- chip select never changes in the same synchronised cycle as a serial-clock edge;
- serial data in is stable around each rising clock edge;
- the protection level does not change during a frame.

The stimulus meets these assumptions in three ways. It drives all pins on the falling system-clock edge. It holds each serial-clock phase for eight system clocks. It waits half a serial-clock period before moving chip select and changes prot_lvl only between frames. Every frame that overlaps a busy interval is also timed to finish before that interval ends. This keeps the moment the busy bit falls outside any frame.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_PERASE = 8'hD8;

  localparam int PAGE_OFF_W  = 8;
  localparam int PAGE_BYTES  = 1 << PAGE_OFF_W;
  localparam int OPCODE_BITS = 8;
  localparam int ERASE_BITS  = 32;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_OPC,
    FR_WREN,
    FR_STAT,
    FR_ADDR,
    FR_DROP
  } frame_st_e;

endpackage

// File: rtl/spi_front.sv
module spi_front #(
  parameter int CNT_W   = 6,
  parameter int SHIFT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_i,
  input  logic               sck_i,
  input  logic               mosi_i,
  input  logic               stat_en_i,
  input  logic [7:0]         stat_word_i,
  output logic               cs_fall_o,
  output logic               cs_rise_o,
  output logic               sck_low_o,
  output logic               bit_stb_o,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic [SHIFT_W-1:0] shreg_o,
  output logic               miso_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [2:0]         cs_q, sck_q;
  logic [1:0]         mosi_q;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [SHIFT_W-1:0] sh_q, sh_n;
  logic               stb_q, stb_n;
  logic [2:0]         idx_q, idx_n;
  logic [7:0]         snap_q, snap_n;
  logic               miso_q, miso_n;
  logic               sel, sck_rise, sck_fall;

  // Synchronised edges
  assign sel       = ~cs_q[1];
  assign cs_fall_o = ~cs_q[1] & cs_q[2];
  assign cs_rise_o = cs_q[1] & ~cs_q[2];
  assign sck_rise  = sck_q[1] & ~sck_q[2];
  assign sck_fall  = ~sck_q[1] & sck_q[2];
  assign sck_low_o = ~sck_q[1];

  always_comb begin
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    stb_n  = sel & sck_rise;
    idx_n  = idx_q;
    snap_n = snap_q;
    miso_n = miso_q;

    if (cs_fall_o)
      cnt_n = '0;
    else if (sel && sck_rise && cnt_q != CNT_MAX)
      cnt_n = cnt_q + 1'b1;

    if (sel && sck_rise)
      sh_n = {sh_q[SHIFT_W-2:0], mosi_q[1]};

    if (!stat_en_i) begin
      miso_n = 1'b0;
      idx_n  = 3'd7;
    end else if (sel && sck_fall) begin
      if (idx_q == 3'd7) begin
        snap_n = stat_word_i;
        miso_n = stat_word_i[7];
      end else begin
        miso_n = snap_q[idx_q];
      end
      idx_n = idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 3'b111;
      sck_q  <= 3'b000;
      mosi_q <= 2'b00;
      cnt_q  <= '0;
      sh_q   <= '0;
      stb_q  <= 1'b0;
      idx_q  <= 3'd7;
      snap_q <= 8'h00;
      miso_q <= 1'b0;
    end else begin
      cs_q   <= {cs_q[1:0], cs_n_i};
      sck_q  <= {sck_q[1:0], sck_i};
      mosi_q <= {mosi_q[0], mosi_i};
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      stb_q  <= stb_n;
      idx_q  <= idx_n;
      snap_q <= snap_n;
      miso_q <= miso_n;
    end
  end

  assign bit_stb_o = stb_q;
  assign bit_cnt_o = cnt_q;
  assign shreg_o   = sh_q;
  assign miso_o    = miso_q;

  // R1: a new frame restarts the bit count
  p_cnt_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_o |=> (bit_cnt_o == '0));

  // R3: output is quiet whenever status is not being returned
  p_miso_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_en_i |=> !miso_o);

endmodule

// File: rtl/pe_ctrl.sv
module pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int PAGE_W       = 2,
  parameter int ERASE_CYCLES = 600,
  parameter int CNT_W        = 6,
  parameter int SHIFT_W      = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs_fall_i,
  input  logic                         cs_rise_i,
  input  logic                         sck_low_i,
  input  logic                         bit_stb_i,
  input  logic [CNT_W-1:0]             bit_cnt_i,
  input  logic [SHIFT_W-1:0]           shreg_i,
  input  logic [1:0]                   prot_lvl_i,
  output logic                         stat_en_o,
  output logic [7:0]                   status_o,
  output logic                         arr_we_o,
  output logic [PAGE_W+PAGE_OFF_W-1:0] arr_waddr_o
);

  localparam int NUM_PAGES = 1 << PAGE_W;
  localparam int EL_W      = $clog2(ERASE_CYCLES + 1);
  localparam logic [EL_W-1:0]   EL_LAST   = EL_W'(ERASE_CYCLES - 1);
  localparam logic [EL_W-1:0]   EL_BYTES  = EL_W'(PAGE_BYTES);
  localparam logic [PAGE_W-1:0] QTR_BASE  = PAGE_W'(NUM_PAGES - NUM_PAGES / 4);
  localparam logic [PAGE_W-1:0] HALF_BASE = PAGE_W'(NUM_PAGES / 2);
  localparam logic [CNT_W-1:0]  CNT_OP    = CNT_W'(OPCODE_BITS);
  localparam logic [CNT_W-1:0]  CNT_PE    = CNT_W'(ERASE_BITS);

  frame_st_e         st_q, st_n;
  logic              wel_q, wel_n;
  logic              busy_q, busy_n;
  logic [EL_W-1:0]   el_q, el_n;
  logic [PAGE_W-1:0] page_q, page_n;

  logic [7:0]        opcode;
  logic [PAGE_W-1:0] req_page;
  logic              locked, wel_set, pe_go;

  assign opcode   = shreg_i[7:0];
  assign req_page = shreg_i[PAGE_OFF_W +: PAGE_W];

  // Protection region decode
  always_comb begin
    unique case (prot_lvl_i)
      2'b00:   locked = 1'b0;
      2'b01:   locked = (req_page >= QTR_BASE);
      2'b10:   locked = (req_page >= HALF_BASE);
      default: locked = 1'b1;
    endcase
  end

  // Frame decoder
  always_comb begin
    st_n = st_q;
    if (cs_rise_i) begin
      st_n = FR_IDLE;
    end else if (cs_fall_i) begin
      st_n = FR_OPC;
    end else if (st_q == FR_OPC && bit_stb_i && bit_cnt_i == CNT_OP) begin
      if (busy_q) begin
        st_n = (opcode == OP_RDSR) ? FR_STAT : FR_DROP;
      end else begin
        unique case (opcode)
          OP_WREN:   st_n = FR_WREN;
          OP_RDSR:   st_n = FR_STAT;
          OP_PERASE: st_n = wel_q ? FR_ADDR : FR_DROP;
          default:   st_n = FR_DROP;
        endcase
      end
    end
  end

  assign wel_set = cs_rise_i && (st_q == FR_WREN) && (bit_cnt_i == CNT_OP);
  assign pe_go   = cs_rise_i && (st_q == FR_ADDR) && (bit_cnt_i == CNT_PE)
                   && sck_low_i && !locked;

  // Latch and erase timer
  always_comb begin
    wel_n  = wel_q;
    busy_n = busy_q;
    el_n   = el_q;
    page_n = page_q;
    if (pe_go) begin
      wel_n  = 1'b0;
      busy_n = 1'b1;
      el_n   = '0;
      page_n = req_page;
    end else begin
      if (wel_set)
        wel_n = 1'b1;
      if (busy_q) begin
        if (el_q == EL_LAST)
          busy_n = 1'b0;
        else
          el_n = el_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      wel_q  <= 1'b0;
      busy_q <= 1'b0;
      el_q   <= '0;
      page_q <= '0;
    end else begin
      st_q   <= st_n;
      wel_q  <= wel_n;
      busy_q <= busy_n;
      el_q   <= el_n;
      page_q <= page_n;
    end
  end

  assign stat_en_o   = (st_q == FR_STAT);
  assign status_o    = {4'b0000, prot_lvl_i, wel_q, busy_q};
  assign arr_we_o    = busy_q && (el_q < EL_BYTES);
  assign arr_waddr_o = {page_q, el_q[PAGE_OFF_W-1:0]};

  // R9: latch is already clear in the first busy cycle
  p_wel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !wel_q);

  // R8: busy holds until the timer reaches its final count
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && el_q != EL_LAST) |=> busy_q);

  // R10: an erase only comes out of an accepted erase frame
  p_busy_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(st_q == FR_ADDR));

  // R7: an erase never starts on a protected page
  p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(!locked));

endmodule

// File: rtl/page_store.sv
module page_store #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
  import flash_pe_pkg::*;
#(
  parameter int ARR_AW       = 10,
  parameter int ERASE_CYCLES = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  input  logic [1:0]        prot_lvl,
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int PAGE_W  = ARR_AW - PAGE_OFF_W;
  localparam int CNT_W   = 6;
  localparam int SHIFT_W = ERASE_BITS;

  logic [1:0]         rst_sync_q;
  logic               rst_n_s;
  logic               cs_fall, cs_rise, sck_low, bit_stb, stat_en, arr_we;
  logic [CNT_W-1:0]   bit_cnt;
  logic [SHIFT_W-1:0] shreg;
  logic [7:0]         status;
  logic [ARR_AW-1:0]  arr_waddr;

  // Reset asserts at once and is released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  spi_front #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) front_i (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .cs_n_i      (cs_n),
    .sck_i       (sck),
    .mosi_i      (mosi),
    .stat_en_i   (stat_en),
    .stat_word_i (status),
    .cs_fall_o   (cs_fall),
    .cs_rise_o   (cs_rise),
    .sck_low_o   (sck_low),
    .bit_stb_o   (bit_stb),
    .bit_cnt_o   (bit_cnt),
    .shreg_o     (shreg),
    .miso_o      (miso)
  );

  pe_ctrl #(
    .PAGE_W       (PAGE_W),
    .ERASE_CYCLES (ERASE_CYCLES),
    .CNT_W        (CNT_W),
    .SHIFT_W      (SHIFT_W)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .cs_fall_i   (cs_fall),
    .cs_rise_i   (cs_rise),
    .sck_low_i   (sck_low),
    .bit_stb_i   (bit_stb),
    .bit_cnt_i   (bit_cnt),
    .shreg_i     (shreg),
    .prot_lvl_i  (prot_lvl),
    .stat_en_o   (stat_en),
    .status_o    (status),
    .arr_we_o    (arr_we),
    .arr_waddr_o (arr_waddr)
  );

  page_store #(.AW(ARR_AW)) store_i (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .we_i    (arr_we),
    .waddr_i (arr_waddr),
    .wdata_i (8'hFF),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  // R4: array writes happen only while the erase timer runs
  p_write_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    arr_we |-> status[0]);

endmodule

// File: tb/flash_erase_ctl_tb_top.sv
module flash_erase_ctl_tb_top;

  localparam int ARR_AW = 10;
  localparam int ERASE  = 2000;
  localparam int DEPTH  = 1 << ARR_AW;
  localparam int HALF   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  logic [1:0] prot_lvl = 2'b00;
  logic [ARR_AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0] mem_m [DEPTH];
  logic wel_m  = 1'b0;
  logic busy_m = 1'b0;

  always #2 clk = ~clk;

  flash_erase_ctl #(.ARR_AW(ARR_AW), .ERASE_CYCLES(ERASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .prot_lvl(prot_lvl), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b);
    mosi = b;
    wait_clk(HALF);
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic spi_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) spi_bit(v[i]);
  endtask

  task automatic spi_start();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic spi_end();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(3 * HALF);
  endtask

  function automatic logic [7:0] exp_status();
    return {4'b0000, prot_lvl, wel_m, busy_m};
  endfunction

  function automatic logic [23:0] page_addr(input int p);
    return 24'h5A0000 | 24'(p << 8) | 24'h37;
  endfunction

  function automatic bit is_locked(input int p);
    case (prot_lvl)
      2'b00:   return 1'b0;
      2'b01:   return p >= 3;
      2'b10:   return p >= 2;
      default: return 1'b1;
    endcase
  endfunction

  // R3: read two status bytes in one frame
  task automatic check_status(input string req);
    logic [7:0] b0, b1;
    spi_start();
    spi_bits(64'h05, 8);
    for (int i = 7; i >= 0; i--) begin
      mosi = 1'b0;
      wait_clk(HALF);
      b0[i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    for (int i = 7; i >= 0; i--) begin
      wait_clk(HALF);
      b1[i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    spi_end();
    chk({req, " status byte R3"}, 32'(b0), 32'(exp_status()));
    chk({req, " repeated status R3"}, 32'(b1), 32'(exp_status()));
  endtask

  task automatic check_array(input string req);
    int bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = ARR_AW'(a);
      #1;
      if (rd_data !== mem_m[a]) bad++;
    end
    chk({req, " array mismatches"}, 32'(bad), 32'd0);
  endtask

  task automatic wren_frame();
    spi_start();
    spi_bits(64'h06, 8);
    spi_end();
    if (!busy_m) wel_m = 1'b1;
  endtask

  // Well-formed erase frame; the model decides whether it runs
  task automatic pe_frame(input int p);
    spi_start();
    spi_bits({32'd0, 8'hD8, page_addr(p)}, 32);
    spi_end();
    if (!busy_m && wel_m && !is_locked(p)) begin
      for (int i = 0; i < 256; i++) mem_m[p * 256 + i] = 8'hFF;
      wel_m  = 1'b0;
      busy_m = 1'b1;
    end
  endtask

  task automatic wait_erase();
    wait_clk(ERASE + 200);
    busy_m = 1'b0;
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) mem_m[a] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R12 reset state
    chk("R12 miso after reset", 32'(miso), 32'd0);
    check_array("R12 reset contents");
    check_status("R12 reset");

    // R5 erase without the latch
    pe_frame(1);
    wait_clk(ERASE + 200);
    check_status("R5 dropped erase");
    check_array("R5 dropped erase");

    // R2 write enable bit count
    spi_start();
    spi_bits(64'h0600, 16);
    spi_end();
    check_status("R2 sixteen-bit write enable");
    wren_frame();
    check_status("R2 write enable");

    // R11 unknown opcode followed by erase-looking bits
    spi_start();
    spi_bits({24'd0, 8'hAA, 8'hD8, page_addr(1)}, 40);
    spi_end();
    check_status("R11 unknown opcode");
    check_array("R11 unknown opcode");

    // R6 framing aborts
    spi_start();
    spi_bits({8'hD8, page_addr(1), 1'b0}, 33);
    spi_end();
    check_array("R6 33 bits");
    spi_start();
    spi_bits({33'd0, 8'hD8, page_addr(1)} >> 1, 31);
    spi_end();
    check_array("R6 31 bits");
    spi_start();
    spi_bits({32'd0, 8'hD8, page_addr(1)} >> 1, 31);
    mosi = 1'b1;
    wait_clk(HALF);
    sck = 1'b1;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
    wait_clk(3 * HALF);
    check_array("R6 rise while clock high");
    check_status("R6 latch kept");

    // R4 R8 R9 R10 accepted erase and commands while busy
    pe_frame(1);
    check_status("R8 R9 busy after start");
    wren_frame();
    check_status("R10 write enable while busy");
    pe_frame(2);
    wait_erase();
    check_status("R8 R9 after erase");
    check_array("R4 R10 page one erased only");

    // R7 protection levels
    prot_lvl = 2'b01;
    wren_frame();
    pe_frame(3);
    check_status("R7 quarter blocked");
    check_array("R7 quarter blocked");
    pe_frame(2);
    wait_erase();
    check_array("R7 R4 page two outside quarter");

    prot_lvl = 2'b11;
    wren_frame();
    pe_frame(0);
    check_array("R7 all blocked");
    prot_lvl = 2'b10;
    pe_frame(3);
    check_status("R7 half blocked");
    pe_frame(0);
    wait_erase();
    check_array("R7 R4 page zero outside half");

    prot_lvl = 2'b00;
    wren_frame();
    pe_frame(3);
    wait_erase();
    check_status("R9 final");
    check_array("R4 last page");

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule